// File: doc/BRIEF.md
# Rotating Display Scan Sequencer

This block is the shared timing source for a spinning persistence-of-vision LED display. It measures the time between rotation reference pulses and splits each turn into equal angular slots. It broadcasts the current slot index. Many LED band controllers can use that index, together with the current group, colour and bit position, so no controller needs its own position logic.

The block also drives the LED driver chips. It produces a gated serial shift clock, a latch strobe and a free-running grayscale PWM clock. After reset it shifts a fixed configuration word out once and latches it. Only then does it enable grayscale writes. From that point, every slot start sweeps through all multiplexing groups. For each group it shifts every colour of every bit, with the most significant bit first, and ends the group with a latch. The shift and grayscale clock rates are set at run time by two half-period inputs.

Top module: `pov_scan_sequencer`

## Requirements
- R1: While reset is held, `cfg_mode` is 1. `angle`, `row` and `colour` are 0, `bit_idx` is BITS-1, and `sclk`, `lat` and `gclk` are all 0.
- R2: After reset, the block gives CFG_W shift clock periods. At each rising edge of `sclk`, `cfg_sdo` carries the bits of CFG_WORD, most significant bit first. Then `lat` is high for exactly one shift clock period, and then `cfg_mode` drops to 0. `gclk` stays low while `cfg_mode` is 1.
- R3: A shift clock period lasts 2*(sclk_half+1) system clock cycles. Once configuration has ended, `gclk` toggles every gclk_half+1 cycles, which gives a period of 2*(gclk_half+1).
- R4: A rising edge on `rot_ref` sets `angle` to 0. The slot length is the number of cycles between the last two reference edges, shifted right by log2(SLOTS). `angle` goes up by one after each slot length and stays at SLOTS-1.
- R5: Until the block has seen two reference edges, `angle` stays 0 and no group write starts (`gs_busy` stays 0).
- R6: Each slot start begins a sweep. Within the sweep, `bit_idx` counts down from BITS-1 to 0 on successive shift clock periods. When `bit_idx` wraps, `colour` advances. When `colour` wraps past COLORS-1, the group ends. Each group gives COLORS*BITS rising edges of `sclk`.
- R7: After the last bit of each group, `lat` is high for one shift clock period and `sclk` is low during that time. `row` then advances to the next group.
- R8: A slot start that arrives while a sweep is running is ignored, so each sweep latches exactly ROWS times. When a sweep ends, `gs_busy` falls, `row` and `colour` are 0 and `bit_idx` is BITS-1.
- R9: `row`, `colour` and `bit_idx` change only while `sclk` is low.
- R10: A sweep has ROWS groups for any value of the ROWS parameter, and its sizes follow COLORS and BITS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rot_ref | input | 1 | Rotation reference, one pulse per turn |
| sclk_half | input | DIV_W | Shift clock half period minus one, in system cycles |
| gclk_half | input | DIV_W | Grayscale clock half period minus one, in system cycles |
| angle | output | log2(SLOTS) | Current angular slot |
| row | output | log2(ROWS) | Current multiplexing group |
| colour | output | log2(COLORS) | Current colour channel |
| bit_idx | output | log2(BITS) | Current grayscale bit, most significant first |
| sclk | output | 1 | Serial shift clock to drivers |
| lat | output | 1 | Latch strobe to drivers |
| gclk | output | 1 | Grayscale PWM clock |
| cfg_mode | output | 1 | High while the configuration write runs |
| cfg_sdo | output | 1 | Configuration serial data |
| gs_busy | output | 1 | High while a group sweep is in progress |

## Verification
The main instance has 4 groups, 3 colours, 4-bit grayscale, an 8-bit configuration word and 4-bit divider fields. A full sweep therefore takes a few hundred cycles, and slot starts at 10 or 20 cycles land inside a running sweep, which tests the ignore rule. The slot count stays at 128, so with a ten-cycle slot the hold at the last slot appears within about 1300 cycles. A second instance with 3 groups, 2 colours and 2 bits shows that the sweep follows a changed group count.

// File: rtl/pov_scan_sequencer.sv
module pov_scan_sequencer #(
  parameter int SLOTS  = 128,
  parameter int ROWS   = 32,
  parameter int COLORS = 3,
  parameter int BITS   = 16,
  parameter int CFG_W  = 16,
  parameter logic [CFG_W-1:0] CFG_WORD = CFG_W'(32'h0000_C3A5),
  parameter int DIV_W  = 8,
  parameter int PER_W  = 22
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rot_ref,
  input  logic [DIV_W-1:0]           sclk_half,
  input  logic [DIV_W-1:0]           gclk_half,
  output logic [$clog2(SLOTS)-1:0]   angle,
  output logic [$clog2(ROWS)-1:0]    row,
  output logic [$clog2(COLORS)-1:0]  colour,
  output logic [$clog2(BITS)-1:0]    bit_idx,
  output logic                       sclk,
  output logic                       lat,
  output logic                       gclk,
  output logic                       cfg_mode,
  output logic                       cfg_sdo,
  output logic                       gs_busy
);
  localparam int ANG_W = $clog2(SLOTS);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLORS);
  localparam int BIT_W = $clog2(BITS);
  localparam int CFG_CW = $clog2(CFG_W);
  localparam int LEN_W = PER_W + 1 - ANG_W;

  typedef enum logic [2:0] {S_CFG, S_CFG_LAT, S_IDLE, S_SHIFT, S_LAT} state_t;
  state_t state;

  logic [DIV_W-1:0] hcnt;
  logic             phase;
  wire div_on   = (state != S_IDLE);
  wire half_end = (hcnt >= sclk_half);
  wire per_end  = div_on && phase && half_end;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hcnt  <= '0;
      phase <= 1'b0;
    end else if (!div_on) begin
      hcnt  <= '0;
      phase <= 1'b0;
    end else if (half_end) begin
      hcnt  <= '0;
      phase <= ~phase;
    end else begin
      hcnt  <= hcnt + 1'b1;
    end

  assign sclk     = phase && (state == S_CFG || state == S_SHIFT);
  assign lat      = (state == S_CFG_LAT) || (state == S_LAT);
  assign cfg_mode = (state == S_CFG) || (state == S_CFG_LAT);
  assign gs_busy  = (state == S_SHIFT) || (state == S_LAT);

  logic [DIV_W-1:0] gcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gcnt <= '0;
      gclk <= 1'b0;
    end else if (cfg_mode) begin
      gcnt <= '0;
      gclk <= 1'b0;
    end else if (gcnt >= gclk_half) begin
      gcnt <= '0;
      gclk <= ~gclk;
    end else begin
      gcnt <= gcnt + 1'b1;
    end

  logic             rot_q, have_ref, slot_go;
  logic [PER_W-1:0] per_cnt;
  logic [LEN_W-1:0] slot_len, slot_t;
  wire rot_edge = rot_ref & ~rot_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rot_q    <= 1'b0;
      have_ref <= 1'b0;
      slot_go  <= 1'b0;
      per_cnt  <= '0;
      slot_len <= '0;
      slot_t   <= '0;
      angle    <= '0;
    end else begin
      rot_q   <= rot_ref;
      slot_go <= 1'b0;
      if (per_cnt != '1) per_cnt <= per_cnt + 1'b1;
      if (rot_edge) begin
        per_cnt  <= '0;
        slot_t   <= '0;
        angle    <= '0;
        have_ref <= 1'b1;
        if (have_ref) begin
          slot_len <= LEN_W'(({1'b0, per_cnt} + 1'b1) >> ANG_W);
          slot_go  <= 1'b1;
        end
      end else if (slot_len != '0) begin
        if (slot_t == slot_len - 1'b1) begin
          slot_t <= '0;
          if (angle != ANG_W'(SLOTS - 1)) begin
            angle   <= angle + 1'b1;
            slot_go <= 1'b1;
          end
        end else begin
          slot_t <= slot_t + 1'b1;
        end
      end
    end

  logic [CFG_W-1:0]  cfg_sr;
  logic [CFG_CW-1:0] cfg_cnt;
  assign cfg_sdo = cfg_sr[CFG_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= S_CFG;
      cfg_sr  <= CFG_WORD;
      cfg_cnt <= '0;
      row     <= '0;
      colour  <= '0;
      bit_idx <= BIT_W'(BITS - 1);
    end else begin
      case (state)
        S_CFG:
          if (per_end) begin
            cfg_sr <= {cfg_sr[CFG_W-2:0], 1'b0};
            if (cfg_cnt == CFG_CW'(CFG_W - 1)) state <= S_CFG_LAT;
            else cfg_cnt <= cfg_cnt + 1'b1;
          end
        S_CFG_LAT:
          if (per_end) state <= S_IDLE;
        S_IDLE:
          if (slot_go) state <= S_SHIFT;
        S_SHIFT:
          if (per_end) begin
            if (bit_idx != '0) begin
              bit_idx <= bit_idx - 1'b1;
            end else begin
              bit_idx <= BIT_W'(BITS - 1);
              if (colour != COL_W'(COLORS - 1)) begin
                colour <= colour + 1'b1;
              end else begin
                colour <= '0;
                state  <= S_LAT;
              end
            end
          end
        S_LAT:
          if (per_end) begin
            if (row == ROW_W'(ROWS - 1)) begin
              row   <= '0;
              state <= S_IDLE;
            end else begin
              row   <= row + 1'b1;
              state <= S_SHIFT;
            end
          end
        default: state <= S_IDLE;
      endcase
    end

  a_r2_gclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode |-> !gclk);
  a_r4_angle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rot_edge |=> angle == '0);
  a_r4_angle_step: assert property (@(posedge clk) disable iff (!rst_n)
    !rot_edge |=> (angle == $past(angle) || angle == $past(angle) + 1'b1));
  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row) < ROWS && int'(colour) < COLORS && int'(bit_idx) < BITS);
  a_r7_lat_no_sclk: assert property (@(posedge clk) disable iff (!rst_n)
    lat |-> !sclk);
  a_r9_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({row, colour, bit_idx}) |-> !sclk);
endmodule

// File: tb/pov_scan_sequencer_test.sv
module pov_scan_sequencer_test;
  localparam int ROWS = 4, COLORS = 3, BITS = 4, CFG_W = 8;
  localparam logic [7:0] WORD = 8'hB4;
  localparam int VEC [4][4] = '{'{0, 0, 2, 2}, '{1, 2, 4, 6}, '{2, 1, 6, 4}, '{3, 5, 8, 12}};

  logic clk = 0, rst_n = 0, rot_ref = 0;
  logic [3:0] sclk_half = 4'd1, gclk_half = 4'd0;
  logic [6:0] angle, b_angle;
  logic [1:0] row, colour, bit_idx, b_row;
  logic [0:0] b_colour, b_bit;
  logic sclk, lat, gclk, cfg_mode, cfg_sdo, gs_busy;
  logic b_sclk, b_lat, b_gclk, b_cfg, b_sdo, b_busy;

  always #5 clk = ~clk;

  pov_scan_sequencer #(.ROWS(ROWS), .COLORS(COLORS), .BITS(BITS), .CFG_W(CFG_W),
    .CFG_WORD(WORD), .DIV_W(4), .PER_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .rot_ref(rot_ref), .sclk_half(sclk_half), .gclk_half(gclk_half),
    .angle(angle), .row(row), .colour(colour), .bit_idx(bit_idx), .sclk(sclk), .lat(lat),
    .gclk(gclk), .cfg_mode(cfg_mode), .cfg_sdo(cfg_sdo), .gs_busy(gs_busy));

  pov_scan_sequencer #(.ROWS(3), .COLORS(2), .BITS(2), .CFG_W(CFG_W),
    .CFG_WORD(WORD), .DIV_W(4), .PER_W(16)) uut_b (
    .clk(clk), .rst_n(rst_n), .rot_ref(rot_ref), .sclk_half(sclk_half), .gclk_half(gclk_half),
    .angle(b_angle), .row(b_row), .colour(b_colour), .bit_idx(b_bit), .sclk(b_sclk), .lat(b_lat),
    .gclk(b_gclk), .cfg_mode(b_cfg), .cfg_sdo(b_sdo), .gs_busy(b_busy));

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  int er = 0, ec = 0, eb = BITS - 1, cfg_rises = 0;
  logic [7:0] cfg_got = '0;
  logic p_sclk = 0;
  logic [5:0] p_pos = '0;
  always @(negedge clk) if (rst_n) begin
    if (sclk && !p_sclk) begin
      if (cfg_mode) begin
        cfg_got = {cfg_got[6:0], cfg_sdo};
        cfg_rises++;
      end else begin
        check(int'(row) == er, "R6 row", row, er);
        check(int'(colour) == ec, "R6 colour", colour, ec);
        check(int'(bit_idx) == eb, "R6 bit", bit_idx, eb);
        if (eb != 0) eb--;
        else begin
          eb = BITS - 1;
          if (ec != COLORS - 1) ec++;
          else begin ec = 0; er = (er + 1) % ROWS; end
        end
      end
    end
    if (sclk && p_sclk)
      check({row, colour, bit_idx} == p_pos, "R9 stable while sclk high", {row, colour, bit_idx}, p_pos);
    p_sclk = sclk;
    p_pos = {row, colour, bit_idx};
  end

  task automatic pulse;
    rot_ref = 1; @(negedge clk); rot_ref = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int latn, busy_seen, ang_bad, g_seen;
    repeat (3) @(negedge clk);
    check(cfg_mode == 1, "R1 cfg_mode", cfg_mode, 1);
    check(angle == 0 && row == 0 && colour == 0, "R1 counters", {angle, row, colour}, 0);
    check(bit_idx == BITS - 1, "R1 bit_idx", bit_idx, BITS - 1);
    check({sclk, lat, gclk} == 0, "R1 clocks", {sclk, lat, gclk}, 0);
    rst_n = 1;

    latn = 0; g_seen = 0;
    do begin
      @(negedge clk);
      if (lat) latn++;
      if (gclk) g_seen = 1;
    end while (cfg_mode);
    check(cfg_rises == CFG_W, "R2 config bit count", cfg_rises, CFG_W);
    check(cfg_got == WORD, "R2 config word", cfg_got, WORD);
    check(latn == 4, "R2 config latch width", latn, 4);
    check(g_seen == 0, "R2 gclk quiet in config", g_seen, 0);

    busy_seen = 0; ang_bad = 0;
    repeat (200) begin @(negedge clk); if (gs_busy) busy_seen = 1; end
    pulse();
    repeat (1279) begin @(negedge clk); if (gs_busy) busy_seen = 1; if (angle != 0) ang_bad = 1; end
    check(busy_seen == 0, "R5 no sweep before two refs", busy_seen, 0);
    check(ang_bad == 0, "R5 angle held at 0", ang_bad, 0);
    pulse();
    repeat (5) @(negedge clk);
    check(angle == 0, "R4 angle at k=5", angle, 0);
    repeat (20) @(negedge clk);
    check(angle == 2, "R4 angle at k=25", angle, 2);
    repeat (1250) @(negedge clk);
    check(angle == 127, "R4 angle last slot", angle, 127);
    repeat (100) @(negedge clk);
    check(angle == 127, "R4 angle holds at end", angle, 127);
    repeat (1184) @(negedge clk);
    pulse();
    check(angle == 0, "R4 angle reset by ref", angle, 0);
    repeat (45) @(negedge clk);
    check(angle == 2, "R4 new slot length 20", angle, 2);

    for (int i = 0; i < 4; i++) begin
      int t, t1, t2, nr, nl, nlr, gt, pl, pg, ps;
      do @(negedge clk); while (gs_busy);
      sclk_half = 4'(VEC[i][0]);
      gclk_half = 4'(VEC[i][1]);
      pg = gclk;
      for (int r = 0; r < 3; ) begin
        @(negedge clk);
        gt++;
        if (gclk && !pg) begin r++; if (r == 2) gt = 0; end
        pg = gclk;
      end
      check(gt == VEC[i][3], "R3 gclk period", gt, VEC[i][3]);
      do @(negedge clk); while (gs_busy);
      do @(negedge clk); while (!gs_busy);
      t = 0; t1 = -1; t2 = -1; nr = 0; nl = 0; nlr = 0; pl = 0; ps = 0;
      while (gs_busy) begin
        if (sclk && !ps) begin
          nr++;
          if (t1 < 0) t1 = t; else if (t2 < 0) t2 = t;
        end
        if (lat) nl++;
        if (lat && !pl) nlr++;
        ps = sclk; pl = lat;
        @(negedge clk);
        t++;
      end
      check(t2 - t1 == VEC[i][2], "R3 sclk period", t2 - t1, VEC[i][2]);
      check(nr == ROWS * COLORS * BITS, "R6 shifts per sweep", nr, ROWS * COLORS * BITS);
      check(nlr == ROWS, "R8 one latch per group, busy starts ignored", nlr, ROWS);
      check(nl == ROWS * VEC[i][2], "R7 latch width", nl, ROWS * VEC[i][2]);
      check(row == 0 && colour == 0 && bit_idx == BITS - 1, "R8 idle state",
            {row, colour, bit_idx}, BITS - 1);
    end

    begin
      int nr, nlr, ps, pl;
      nr = 0; nlr = 0; ps = 0; pl = 0;
      do @(negedge clk); while (b_busy);
      do @(negedge clk); while (!b_busy);
      while (b_busy) begin
        if (b_sclk && !ps) nr++;
        if (b_lat && !pl) nlr++;
        ps = b_sclk; pl = b_lat;
        @(negedge clk);
      end
      check(nlr == 3, "R10 groups with ROWS=3", nlr, 3);
      check(nr == 12, "R10 shifts with ROWS=3", nr, 12);
      check(b_row == 0, "R10 row back to 0", b_row, 0);
    end
    summary();
  end
endmodule